// File: doc/BRIEF.md
# Burst Wrap Address Generator

This block produces the byte addresses for a burst read on a flash-side or cache-fill data path. A stored three-bit wrap setting chooses how the addresses move. With wrapping off, the counter steps linearly through the whole address space. With wrapping on, the counter stays inside an aligned window of 8, 16, 32 or 64 bytes, so a cache line can be filled beginning at its critical byte.

A burst begins when a start strobe arrives while chip select is low. The strobe loads the initial address and freezes the wrap setting for that burst. Each advance strobe steps the address by one byte. Raising chip select ends the burst. The wrap setting can be rewritten at any time, but a new value is used only from the next start onward.

Top module: `burst_wrap_addr`

## Requirements
- R1: After reset, `active` is 0, `addr` is 0 and the stored wrap setting is 3'b001, which means wrapping is disabled.
- R2: A cycle with `cs_n` low and `start` high makes `addr` equal `start_addr` and `active` equal 1 on the next cycle. This holds even if `advance` is high in the same cycle.
- R3: With wrapping disabled, each `advance` during an active burst adds 1 to `addr` modulo 2^24, so FFFFFFh is followed by 000000h.
- R4: The wrap setting is `cfg_wrap[2:0]`. Bit 0 = 0 enables wrapping and bit 0 = 1 disables it. Bits [2:1] give the window size: 00 is 8 bytes, 01 is 16, 10 is 32 and 11 is 64. With wrapping enabled, each advance increments only the low window bits, modulo the window size, and leaves all higher bits unchanged.
- R5: When `cs_n` is high, `active` goes to 0 on the next cycle. While `active` is 0 and no start is accepted, `addr` holds its value even if `advance` is pulsed.
- R6: A wrap setting written with `cfg_we` takes effect at the next accepted start. A write during a burst does not change that burst. When `cfg_we` and an accepted start fall in the same cycle, the burst uses the setting stored before that write.
- R7: A `start` with `cs_n` high is ignored, and `addr` does not change.
- R8: A start accepted while a burst is active restarts the burst at the new `start_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the wrap setting |
| cfg_wrap | input | 3 | Wrap setting: [2:1] window size, [0] wrap disable |
| cs_n | input | 1 | Chip select, active low; high ends the burst |
| start | input | 1 | Load `start_addr` and begin a burst |
| start_addr | input | 24 | Initial byte address of the burst |
| advance | input | 1 | Step to the next byte |
| addr | output | 24 | Current byte address |
| active | output | 1 | A burst is in progress |

## Verification
Two pairs of functions can fall in the same cycle. The first is a configuration write and a burst start. The bench raises `cfg_we` and `start` on the same edge, then advances across the window boundary. The resulting address shows which setting the burst used: it must be the old one, while the next burst picks up the new one. The second pair is start and advance on the same edge, where the loaded address must win over the step.

// File: rtl/burst_wrap_addr.sv
module burst_wrap_addr #(
  parameter int ADDR_W    = 24,
  parameter int MIN_WIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wrap,
  input  logic              cs_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              active
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [2:0]        cfg_q;
  logic              wrap_on;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] cfg_mask;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] addr_next;
  logic              take_start;

  assign take_start = !cs_n && start;
  assign cfg_mask   = (ONE << (MIN_WIN_W + int'(cfg_q[2:1]))) - ONE;
  assign addr_inc   = addr + ONE;
  assign addr_next  = wrap_on ? ((addr & ~win_mask) | (addr_inc & win_mask)) : addr_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= 3'b001;
    else if (cfg_we) cfg_q <= cfg_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      active   <= 1'b0;
      wrap_on  <= 1'b0;
      win_mask <= '0;
    end else if (take_start) begin
      addr     <= start_addr;
      active   <= 1'b1;
      wrap_on  <= !cfg_q[0];
      win_mask <= cfg_mask;
    end else if (cs_n) begin
      active   <= 1'b0;
    end else if (active && advance) begin
      addr     <= addr_next;
    end
  end
endmodule

module burst_wrap_addr_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              advance,
  input logic [ADDR_W-1:0] addr,
  input logic              active,
  input logic              wrap_on,
  input logic [ADDR_W-1:0] win_mask
);
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start) |=> (active && addr == $past(start_addr)));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n && !start && advance && !wrap_on) |=> (addr == $past(addr) + 1'b1));

  p_window_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n && !start && advance && wrap_on)
      |=> (((addr ^ $past(addr)) & ~$past(win_mask)) == '0));

  p_cs_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!active && $stable(addr)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(start && !cs_n)) |=> $stable(addr));
endmodule

bind burst_wrap_addr burst_wrap_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .start_addr(start_addr),
  .advance(advance), .addr(addr), .active(active), .wrap_on(wrap_on), .win_mask(win_mask)
);

// File: tb/tb_burst_wrap_addr.sv
module tb_burst_wrap_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wrap = 3'b000;
  logic        cs_n = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        advance = 1'b0;
  logic [23:0] addr;
  logic        active;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  burst_wrap_addr dut (.*);

  // {cfg[2:0], start[23:0], advances[7:0], expected[23:0]}
  localparam logic [58:0] VEC [8] = '{
    {3'b001, 24'h000010, 8'd5,  24'h000015},
    {3'b001, 24'hFFFFFE, 8'd3,  24'h000001},
    {3'b000, 24'h123456, 8'd3,  24'h123451},
    {3'b010, 24'h0000FE, 8'd5,  24'h0000F3},
    {3'b100, 24'h00AB3C, 8'd10, 24'h00AB26},
    {3'b110, 24'h7FFFFF, 8'd1,  24'h7FFFC0},
    {3'b111, 24'h0000FF, 8'd1,  24'h000100},
    {3'b000, 24'h000007, 8'd16, 24'h000007}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wrap = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic begin_burst(input logic [23:0] a);
    @(negedge clk); cs_n = 1'b0; start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); advance = 1'b1;
    end
    @(negedge clk); advance = 1'b0;
  endtask

  task automatic end_burst();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", addr, 24'h0);
    chk("R1 active", {23'b0, active}, 24'h0);
    rst_n = 1'b1;
    // R1: default setting is linear
    begin_burst(24'h0000FE);
    steps(3);
    chk("R1 default linear", addr, 24'h000101);
    end_burst();

    for (int k = 0; k < 8; k++) begin
      write_cfg(VEC[k][58:56]);
      begin_burst(VEC[k][55:32]);
      chk("R2 load", addr, VEC[k][55:32]);
      steps(int'(VEC[k][31:24]));
      chk("R3/R4 vector", addr, VEC[k][23:0]);
      end_burst();
    end

    // R6: a write during a burst is ignored
    write_cfg(3'b000);
    begin_burst(24'h000006);
    write_cfg(3'b001);
    steps(3);
    chk("R6 mid-burst write", addr, 24'h000001);
    end_burst();

    // R6: cfg_we and start in the same cycle
    write_cfg(3'b000);
    @(negedge clk); cs_n = 1'b0; start = 1'b1; start_addr = 24'h00000E;
    cfg_we = 1'b1; cfg_wrap = 3'b001;
    @(negedge clk); start = 1'b0; cfg_we = 1'b0;
    steps(3);
    chk("R6 same-cycle old setting", addr, 24'h000009);
    end_burst();
    begin_burst(24'h00000E);
    steps(3);
    chk("R6 next burst new setting", addr, 24'h000011);

    // R5: cs_n high ends the burst and advance is ignored
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    chk("R5 active low", {23'b0, active}, 24'h0);
    steps(4);
    chk("R5 advance ignored", addr, 24'h000011);

    // R7: start with cs_n high is ignored
    @(negedge clk); start = 1'b1; start_addr = 24'hABCDEF;
    @(negedge clk); start = 1'b0;
    chk("R7 start ignored", addr, 24'h000011);
    chk("R7 still idle", {23'b0, active}, 24'h0);

    // R8 and R2: restart mid-burst, start wins over advance
    write_cfg(3'b001);
    begin_burst(24'h000100);
    steps(2);
    @(negedge clk); start = 1'b1; advance = 1'b1; start_addr = 24'h000500;
    @(negedge clk); start = 1'b0; advance = 1'b0;
    chk("R8 restart with advance", addr, 24'h000500);
    steps(1);
    chk("R8 continues", addr, 24'h000501);
    end_burst();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule